// File: doc/BRIEF.md
# Raster timing generator

The block produces the pixel-clock output, horizontal and vertical sync, data-enable and the active-area pixel coordinates for a TFT raster panel. It runs on one reference clock and makes the pixel rate with an integer divider, so every output is a plain reference-clock signal and a pixel lasts exactly N reference cycles.

Four packed configuration words set the timing. The horizontal word holds the sync width and both porches. The vertical word holds the sync height and both vertical porches. The area word holds the active width, in groups of 16 pixels, and the active height. The control word holds the divisor, the three output inversions and the sync-edge selection. A raster-enable input starts and stops scanning. The words are captured into a shadow bank only while scanning is off or at the last reference cycle of a frame, so software may rewrite them at any time and a frame never mixes two settings.

Each line runs sync, back porch, active, front porch, and each frame steps through lines in the same order. The stream feeds the pixel-data path, which sits outside this block.

Top module: `lcd_raster_timer`

## Requirements
- R1: The divisor sits in `cfg_ctl[7:0]`. Each pixel lasts N reference cycles. The non-inverted pixel clock is low for the first floor(N/2) cycles of a pixel and high for the rest. Every timing output steps at the start of a pixel.
- R2: A divisor of 0 or 1 acts as 2.
- R3: `cfg_hor[9:0]` holds the horizontal sync width, `[19:10]` the back porch and `[29:20]` the front porch, each stored as pixels minus one. `cfg_area[6:0]` holds (width-1)>>4, giving an active width of 16*(value+1). A line is sync, back porch, active, then front porch.
- R4: `cfg_ver[5:0]` holds the sync height as lines minus one. `[13:6]` holds the back porch and `[21:14]` the front porch, both in lines with no offset, and 0 is allowed. `cfg_area[17:7]` holds the active lines minus one. A frame is sync lines, back-porch lines, active lines, then front-porch lines.
- R5: `de_o` is high only when both the horizontal and vertical positions are active. `x_o` gives the pixel index from the first active pixel while the line is in its active span and is 0 elsewhere. `y_o` gives the line index from the first active line while in the active lines and is 0 elsewhere. Sync outputs are active-high when not inverted.
- R6: `cfg_ctl[8]` inverts `hsync_o`, `[9]` inverts `vsync_o` and `[10]` inverts `pclk_o`.
- R7: When `cfg_ctl[11]` (sync-edge select) and `cfg_ctl[12]` (rising edge) are both 1, the sync outputs step floor(N/2) cycles into each pixel, on the rising pixel clock, and are inactive during the first half of the first pixel after enable. Otherwise they step with the data-enable. Bit 12 alone has no effect.
- R8: While `raster_en` is low, `de_o`, `x_o` and `y_o` are 0, the syncs and pixel clock rest at their inactive levels, and the position returns to the top-left. Setting `raster_en` again starts a fresh frame from the first sync pixel.
- R9: Configuration words are captured only while `raster_en` is low or at the end of a frame. A write during a frame takes effect at the next frame.
- R10: Under reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raster_en | input | 1 | Scanning enable |
| cfg_hor | input | 30 | Horizontal sync and porch word |
| cfg_ver | input | 22 | Vertical sync and porch word |
| cfg_area | input | 18 | Active width and height word |
| cfg_ctl | input | 13 | Divisor, inversions and sync-edge selection |
| pclk_o | output | 1 | Pixel clock output |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| x_o | output | 11 | Active pixel index |
| y_o | output | 11 | Active line index |

## Verification
A reference model in the bench expands each setting into a pixel list and then into reference cycles, so every output is compared on every cycle.

- An odd divisor with asymmetric porches shows whether the minus-one fields are decoded correctly and whether the pixel clock splits the pixel at floor(N/2).
- A setting with every inversion on, late syncs and zero vertical porches tells the direct vertical encoding and the half-pixel sync delay apart from the default path. Running each sync-edge bit on its own shows that neither acts alone.
- Divisors 0, 1 and 255 probe the clamp and the long count.
- A write in the middle of a frame with a different width and divisor shows whether the shadow bank holds the old setting until the frame ends.
- A partial frame, a pause and a re-enable show that scanning restarts from the top-left.

// File: rtl/lcd_raster_pkg.sv
`timescale 1ns/1ps
package lcd_raster_pkg;
  parameter int HS_W  = 10;
  parameter int VS_W  = 6;
  parameter int VP_W  = 8;
  parameter int WQ_W  = 7;
  parameter int LN_W  = 11;
  parameter int DIV_W = 8;

  localparam int HOR_W  = 3 * HS_W;
  localparam int VER_W  = VS_W + 2 * VP_W;
  localparam int AREA_W = WQ_W + LN_W;
  localparam int CTL_W  = DIV_W + 5;
  localparam int XW     = WQ_W + 4;
  localparam int YW     = LN_W;
  localparam int HCNT_W = $clog2(3 * (2 ** HS_W) + 2 ** XW + 1);
  localparam int VCNT_W = $clog2(2 ** VS_W + 2 * (2 ** VP_W) + 2 ** LN_W + 1);

  typedef struct packed {
    logic [HS_W-1:0] h_front_m1;
    logic [HS_W-1:0] h_back_m1;
    logic [HS_W-1:0] h_sync_m1;
  } hor_t;

  typedef struct packed {
    logic [VP_W-1:0] v_front;
    logic [VP_W-1:0] v_back;
    logic [VS_W-1:0] v_sync_m1;
  } ver_t;

  typedef struct packed {
    logic [LN_W-1:0] lines_m1;
    logic [WQ_W-1:0] width_q;
  } area_t;

  typedef struct packed {
    logic             sync_rise;
    logic             sync_sel;
    logic             inv_pclk;
    logic             inv_vs;
    logic             inv_hs;
    logic [DIV_W-1:0] divisor;
  } ctl_t;

  typedef struct packed {
    hor_t  hor;
    ver_t  ver;
    area_t area;
    ctl_t  ctl;
  } cfg_t;
endpackage

// File: rtl/lcd_pixclk_div.sv
`timescale 1ns/1ps
module lcd_pixclk_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] divisor,
  output logic          tick,
  output logic          half_tick,
  output logic          pclk_lvl
);
  logic [DW-1:0] cnt_q, cnt_d, half;

  always_comb begin
    half      = divisor >> 1;
    tick      = run && (cnt_q == divisor - 1'b1);
    half_tick = run && (cnt_q == half - 1'b1);
    pclk_lvl  = run && (cnt_q >= half);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < divisor)); // R1
endmodule

// File: rtl/lcd_axis_seq.sv
`timescale 1ns/1ps
module lcd_axis_seq #(
  parameter int CNT_W = 13,
  parameter int OUT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             adv,
  input  logic [CNT_W-1:0] sync_len,
  input  logic [CNT_W-1:0] back_len,
  input  logic [CNT_W-1:0] act_len,
  input  logic [CNT_W-1:0] front_len,
  output logic             in_sync,
  output logic             in_act,
  output logic             last,
  output logic [OUT_W-1:0] act_pos
);
  logic [CNT_W-1:0] pos_q, pos_d, act_start, act_end, total;

  always_comb begin
    act_start = sync_len + back_len;
    act_end   = act_start + act_len;
    total     = act_end + front_len;
    last      = (pos_q == total - 1'b1);
    in_sync   = run && (pos_q < sync_len);
    in_act    = run && (pos_q >= act_start) && (pos_q < act_end);
    act_pos   = in_act ? OUT_W'(pos_q - act_start) : '0;
    if (!run)     pos_d = '0;
    else if (adv) pos_d = last ? '0 : pos_q + 1'b1;
    else          pos_d = pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  AST_IDLE_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos_q == '0)); // R8
  AST_POS_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos_q < total)); // R3
endmodule

// File: rtl/lcd_raster_timer.sv
`timescale 1ns/1ps
module lcd_raster_timer
  import lcd_raster_pkg::*;
(
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              raster_en,
  input  logic [HOR_W-1:0]  cfg_hor,
  input  logic [VER_W-1:0]  cfg_ver,
  input  logic [AREA_W-1:0] cfg_area,
  input  logic [CTL_W-1:0]  cfg_ctl,
  output logic              pclk_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [XW-1:0]     x_o,
  output logic [YW-1:0]     y_o
);
  cfg_t shd_q, shd_d, cfg_in;
  logic [DIV_W-1:0] div_eff;
  logic tick, half_tick, pclk_lvl;
  logic [HCNT_W-1:0] h_sync_len, h_back_len, h_act_len, h_front_len;
  logic [VCNT_W-1:0] v_sync_len, v_back_len, v_act_len, v_front_len;
  logic h_sync, h_act, h_last, v_sync, v_act, v_last;
  logic frame_wrap, use_late;
  logic [1:0] sync_now, late_q, late_d, sync_sel;

  // shadow bank: follows the inputs while idle, reloads at frame end
  always_comb begin
    cfg_in.hor  = hor_t'(cfg_hor);
    cfg_in.ver  = ver_t'(cfg_ver);
    cfg_in.area = area_t'(cfg_area);
    cfg_in.ctl  = ctl_t'(cfg_ctl);
    shd_d = (!raster_en || frame_wrap) ? cfg_in : shd_q;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) shd_q <= '0;
    else        shd_q <= shd_d;
  end

  // field decode into lengths
  always_comb begin
    div_eff     = (shd_q.ctl.divisor < DIV_W'(2)) ? DIV_W'(2) : shd_q.ctl.divisor;
    h_sync_len  = HCNT_W'(shd_q.hor.h_sync_m1) + 1'b1;
    h_back_len  = HCNT_W'(shd_q.hor.h_back_m1) + 1'b1;
    h_front_len = HCNT_W'(shd_q.hor.h_front_m1) + 1'b1;
    h_act_len   = HCNT_W'({shd_q.area.width_q, 4'hF}) + 1'b1;
    v_sync_len  = VCNT_W'(shd_q.ver.v_sync_m1) + 1'b1;
    v_back_len  = VCNT_W'(shd_q.ver.v_back);
    v_front_len = VCNT_W'(shd_q.ver.v_front);
    v_act_len   = VCNT_W'(shd_q.area.lines_m1) + 1'b1;
  end

  lcd_pixclk_div #(.DW(DIV_W)) u_div (
    .clk(clk_ref), .rst_n(rst_n), .run(raster_en), .divisor(div_eff),
    .tick(tick), .half_tick(half_tick), .pclk_lvl(pclk_lvl)
  );

  lcd_axis_seq #(.CNT_W(HCNT_W), .OUT_W(XW)) u_hax (
    .clk(clk_ref), .rst_n(rst_n), .run(raster_en), .adv(tick),
    .sync_len(h_sync_len), .back_len(h_back_len), .act_len(h_act_len), .front_len(h_front_len),
    .in_sync(h_sync), .in_act(h_act), .last(h_last), .act_pos(x_o)
  );

  lcd_axis_seq #(.CNT_W(VCNT_W), .OUT_W(YW)) u_vax (
    .clk(clk_ref), .rst_n(rst_n), .run(raster_en), .adv(tick && h_last),
    .sync_len(v_sync_len), .back_len(v_back_len), .act_len(v_act_len), .front_len(v_front_len),
    .in_sync(v_sync), .in_act(v_act), .last(v_last), .act_pos(y_o)
  );

  assign frame_wrap = tick && h_last && v_last;
  assign use_late   = shd_q.ctl.sync_sel && shd_q.ctl.sync_rise;
  assign sync_now   = {v_sync, h_sync};

  // half-pixel delayed copy of the syncs, one bit per axis
  for (genvar g = 0; g < 2; g++) begin : g_late
    always_comb begin
      if (!raster_en)     late_d[g] = 1'b0;
      else if (half_tick) late_d[g] = sync_now[g];
      else                late_d[g] = late_q[g];
      sync_sel[g] = use_late ? late_q[g] : sync_now[g];
    end
    always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) late_q[g] <= 1'b0;
      else        late_q[g] <= late_d[g];
    end
  end

  assign hsync_o = sync_sel[0] ^ shd_q.ctl.inv_hs;
  assign vsync_o = sync_sel[1] ^ shd_q.ctl.inv_vs;
  assign pclk_o  = pclk_lvl ^ shd_q.ctl.inv_pclk;
  assign de_o    = h_act && v_act;

  AST_SHADOW_HELD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (raster_en && !frame_wrap) |=> $stable(shd_q)); // R9
  AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk_ref) disable iff (!rst_n)
    de_o |-> !(h_sync || v_sync)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !raster_en |-> (!de_o && x_o == '0 && y_o == '0)); // R8
  AST_WRAP_ON_TICK: assert property (@(posedge clk_ref) disable iff (!rst_n)
    frame_wrap |=> (x_o == '0 && y_o == '0 && !de_o)); // R4
endmodule

// File: tb/lcd_raster_timer_test.sv
`timescale 1ns/1ps
module lcd_raster_timer_test;
  import lcd_raster_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk_ref = 1'b0;
  logic rst_n, raster_en;
  logic [HOR_W-1:0] cfg_hor;
  logic [VER_W-1:0] cfg_ver;
  logic [AREA_W-1:0] cfg_area;
  logic [CTL_W-1:0] cfg_ctl;
  logic pclk_o, hsync_o, vsync_o, de_o;
  logic [XW-1:0] x_o;
  logic [YW-1:0] y_o;

  int n_checks = 0;
  int n_fail = 0;
  bit mon_on = 0;
  bit done = 0;
  int mon_idx = 0;
  string cur_tag = "";

  typedef struct {
    int hsw, hbp, wid, hfp, vsw, vbp, lin, vfp, div;
    int ihs, ivs, ipc, ssel, srise;
  } tcfg_t;

  typedef struct packed {
    logic hs, vs, de;
    logic [XW-1:0] x;
    logic [YW-1:0] y;
    int dv;
    logic ihs, ivs, ipc, late;
  } pix_t;

  typedef struct packed {
    logic hs, vs, de, pc;
    logic [XW-1:0] x;
    logic [YW-1:0] y;
  } obs_t;

  pix_t pix_q[$];
  obs_t exp_q[$];

  lcd_raster_timer uut (
    .clk_ref(clk_ref), .rst_n(rst_n), .raster_en(raster_en),
    .cfg_hor(cfg_hor), .cfg_ver(cfg_ver), .cfg_area(cfg_area), .cfg_ctl(cfg_ctl),
    .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .x_o(x_o), .y_o(y_o)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  task automatic drive(input tcfg_t c);
    cfg_hor  = {10'(c.hfp - 1), 10'(c.hbp - 1), 10'(c.hsw - 1)};
    cfg_ver  = {8'(c.vfp), 8'(c.vbp), 6'(c.vsw - 1)};
    cfg_area = {11'(c.lin - 1), 7'((c.wid - 1) >> 4)};
    cfg_ctl  = {1'(c.srise), 1'(c.ssel), 1'(c.ipc), 1'(c.ivs), 1'(c.ihs), 8'(c.div)};
  endtask

  task automatic model_frames(input tcfg_t c, input int nfr);
    int ht = c.hsw + c.hbp + c.wid + c.hfp;
    int vt = c.vsw + c.vbp + c.lin + c.vfp;
    for (int f = 0; f < nfr; f++) begin
      for (int yy = 0; yy < vt; yy++) begin
        for (int xx = 0; xx < ht; xx++) begin
          pix_t p;
          bit ha = (xx >= c.hsw + c.hbp) && (xx < c.hsw + c.hbp + c.wid);
          bit va = (yy >= c.vsw + c.vbp) && (yy < c.vsw + c.vbp + c.lin);
          p.hs   = (xx < c.hsw);
          p.vs   = (yy < c.vsw);
          p.de   = ha && va;
          p.x    = ha ? XW'(xx - c.hsw - c.hbp) : '0;
          p.y    = va ? YW'(yy - c.vsw - c.vbp) : '0;
          p.dv   = (c.div < 2) ? 2 : c.div;
          p.ihs  = 1'(c.ihs);
          p.ivs  = 1'(c.ivs);
          p.ipc  = 1'(c.ipc);
          p.late = (c.ssel != 0) && (c.srise != 0);
          pix_q.push_back(p);
        end
      end
    end
  endtask

  task automatic expand(input int ncyc);
    int t = 0;
    for (int i = 0; i < pix_q.size(); i++) begin
      for (int c = 0; c < pix_q[i].dv; c++) begin
        obs_t o;
        int half = pix_q[i].dv / 2;
        logic shs, svs;
        if (t >= ncyc) return;
        if (c >= half) begin
          shs = pix_q[i].hs; svs = pix_q[i].vs;
        end else if (i == 0) begin
          shs = 1'b0; svs = 1'b0;
        end else begin
          shs = pix_q[i-1].hs; svs = pix_q[i-1].vs;
        end
        o.hs = (pix_q[i].late ? shs : pix_q[i].hs) ^ pix_q[i].ihs;
        o.vs = (pix_q[i].late ? svs : pix_q[i].vs) ^ pix_q[i].ivs;
        o.pc = (c >= half) ^ pix_q[i].ipc;
        o.de = pix_q[i].de;
        o.x  = pix_q[i].x;
        o.y  = pix_q[i].y;
        exp_q.push_back(o);
        t++;
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_ref) begin
    #1;
    if (mon_on && exp_q.size() > 0) begin
      obs_t e, a;
      e = exp_q.pop_front();
      a = {hsync_o, vsync_o, de_o, pclk_o, x_o, y_o};
      n_checks++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s cycle %0d: got hs=%0b vs=%0b de=%0b pclk=%0b x=%0d y=%0d, expected hs=%0b vs=%0b de=%0b pclk=%0b x=%0d y=%0d",
                 cur_tag, mon_idx, a.hs, a.vs, a.de, a.pc, a.x, a.y,
                 e.hs, e.vs, e.de, e.pc, e.x, e.y);
      end
      mon_idx++;
    end
  end

  task automatic run_case(input tcfg_t c1, input tcfg_t c2, input int chg_at,
                          input int nfr, input int ncyc, input string tag);
    int t = 0;
    pix_q.delete();
    exp_q.delete();
    if (chg_at > 0) begin
      model_frames(c1, 1);
      model_frames(c2, nfr - 1);
    end else begin
      model_frames(c1, nfr);
    end
    expand(ncyc);
    @(negedge clk_ref);
    raster_en = 1'b0;
    drive(c1);
    repeat (2) @(negedge clk_ref);
    cur_tag = tag;
    mon_idx = 0;
    raster_en = 1'b1;
    mon_on = 1'b1;
    while (exp_q.size() > 0) begin
      @(negedge clk_ref);
      t++;
      if (t == chg_at) drive(c2);
    end
    mon_on = 1'b0;
    raster_en = 1'b0;
  endtask

  task automatic check_idle(input logic ehs, input logic evs, input logic epc, input string tag);
    repeat (3) @(negedge clk_ref);
    #1;
    n_checks++;
    if ({hsync_o, vsync_o, pclk_o, de_o} !== {ehs, evs, epc, 1'b0} || x_o !== '0 || y_o !== '0) begin
      n_fail++;
      $display("FAIL %s idle: got hs=%0b vs=%0b pclk=%0b de=%0b x=%0d y=%0d, expected hs=%0b vs=%0b pclk=%0b de=0 x=0 y=0",
               tag, hsync_o, vsync_o, pclk_o, de_o, x_o, y_o, ehs, evs, epc);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    tcfg_t a, b, c, d, e, f;
    rst_n = 1'b0;
    raster_en = 1'b0;
    cfg_hor = '0; cfg_ver = '0; cfg_area = '0; cfg_ctl = '0;
    repeat (3) @(negedge clk_ref);
    #1;
    // R10: outputs under reset
    n_checks++;
    if ({pclk_o, hsync_o, vsync_o, de_o} !== 4'b0 || x_o !== '0 || y_o !== '0) begin
      n_fail++;
      $display("FAIL R10 reset: got pclk=%0b hs=%0b vs=%0b de=%0b x=%0d y=%0d, expected all 0",
               pclk_o, hsync_o, vsync_o, de_o, x_o, y_o);
    end
    @(negedge clk_ref);
    rst_n = 1'b1;

    a = '{hsw:2, hbp:3, wid:16, hfp:2, vsw:1, vbp:1, lin:3, vfp:1, div:3,
          ihs:0, ivs:0, ipc:0, ssel:0, srise:0};
    // R1 R3 R4 R5: odd divisor, basic frame order
    run_case(a, a, 0, 2, 1000000, "R1 R3 R4 R5 base");

    b = '{hsw:1, hbp:1, wid:32, hfp:1, vsw:2, vbp:0, lin:2, vfp:0, div:2,
          ihs:1, ivs:1, ipc:1, ssel:1, srise:1};
    // R4 R6 R7: zero vertical porches, inversions, late syncs
    run_case(b, b, 0, 2, 1000000, "R4 R6 R7 inverted late");
    check_idle(1'b1, 1'b1, 1'b1, "R8 R6 idle inverted");

    c = a; c.div = 4; c.ssel = 1; c.srise = 0;
    run_case(c, c, 0, 1, 1000000, "R7 select without rise");
    d = a; d.div = 4; d.ssel = 0; d.srise = 1;
    run_case(d, d, 0, 1, 1000000, "R7 rise alone ignored");
    d.ssel = 1; d.vsw = 2; d.hsw = 3;
    run_case(d, d, 0, 1, 1000000, "R7 late with even divisor");

    e = a; e.div = 1;
    run_case(e, e, 0, 1, 1000000, "R2 divisor 1");
    e.div = 0;
    run_case(e, e, 0, 1, 300, "R2 divisor 0");

    f = a; f.wid = 32; f.hsw = 3; f.vbp = 2; f.lin = 2; f.div = 4; f.ihs = 1;
    // R9: write mid-frame, effective only at next frame
    run_case(a, f, 50, 2, 1000000, "R9 mid-frame write");

    // R8: partial frame, pause, restart from the top-left
    run_case(a, a, 0, 1, 250, "R8 partial frame");
    check_idle(1'b0, 1'b0, 1'b0, "R8 idle");
    run_case(a, a, 0, 1, 1000000, "R8 restart");

    e = a; e.div = 255;
    run_case(e, e, 0, 1, 1200, "R1 divisor 255");

    repeat (2) @(negedge clk_ref);
    finish_up();
  end
endmodule